// File: doc/BRIEF.md
# Windowed Address Translation Unit

This block rewrites addresses for a bus bridge. It keeps two independent sets of translation windows, one for traffic entering the chip and one for traffic leaving it, with up to sixteen windows in each set. Software programs a window through a small register page. A selection register picks the direction and the window number, and a group of shared registers then reads and writes the lower bound, upper bound, destination and two control words of that window only.

A window is only stored when its bounds and destination are written. Its live mapping is reloaded from those stored values at the moment its second control word is written, and that word also carries the enable bit. A lookup presents an address and a direction. The lowest-numbered enabled window whose range contains the address rewrites it to destination + (address - lower bound), and the result appears one clock later. A window whose type word is non-zero produces a configuration access instead: bus number, device/function number and a register offset are taken from the destination and the distance into the window. An address that no window claims passes through unchanged and is flagged as a miss. Three fixed status words complete the register page.

Top module: `atu_xlate`

## Requirements
- R1: After reset every window has lower bound 0, destination 0, upper bound register 0xFFFF_FFFF and type word 0. The enable word of inbound window 0 reads 0x8000_0000 and that window translates. Every other enable word reads 0, the selection register reads 0 and resValid is low.
- R2: The selection register at 0x900 stores bit 31 as the direction (1 inbound, 0 outbound) and bits 3:0 as the window number. All other bits read back as 0.
- R3: The per-window registers of the selected window read back the last value written: type 0x904, enable 0x908, lower bound low/high 0x90C/0x910, upper bound 0x914, destination low/high 0x918/0x91C.
- R4: Writes to bounds, destination and type change no lookup result until 0x908 is written. A lookup in the same cycle as that write still uses the old mapping.
- R5: A window matches when its enable bit (0x908 bit 31) is set and lower ≤ address ≤ {lower[63:32], upper}. The result address is destination + address - lower, and resIndex is the window number.
- R6: When several enabled windows of one direction match, the lowest number wins.
- R7: With no match, resMiss is 1, resAddr equals the looked-up address, resIndex is 0 and resCfg is 0.
- R8: A window with a non-zero type word sets resCfg. resBus is destination bits 31:24, resDevFn is destination bits 23:16 and resOffset is the low OFFS_W bits of address - lower. These three fields are 0 when resCfg is 0.
- R9: A write to 0x91C replaces destination bits 63:32 and keeps bits 31:0.
- R10: 0x72C reads 0x0000_0010, 0x80C reads 0x0002_0000 and 0x710 reads 0. Writes to these three offsets change no state.
- R11: resValid and the result fields follow lkValid exactly one clock later.
- R12: A lookup uses only the windows of its own direction.
- R13: With a window number ≥ NUM_VP selected, per-window writes are dropped and per-window reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 12 | Register byte offset (reads and writes) |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data, combinational from regAddr |
| lkValid | input | 1 | Lookup request |
| lkInbound | input | 1 | Lookup direction, 1 = inbound |
| lkAddr | input | 64 | Address to translate |
| resValid | output | 1 | Result valid |
| resMiss | output | 1 | No window matched |
| resCfg | output | 1 | Matching window is configuration type |
| resIndex | output | 4 | Number of the matching window |
| resAddr | output | 64 | Translated or passed-through address |
| resBus | output | 8 | Configuration bus number |
| resDevFn | output | 8 | Configuration device/function number |
| resOffset | output | OFFS_W | Configuration register offset |

## Verification
The hardest case to reach is the moment a window's mapping changes. The new bounds must already sit in the stored registers but stay invisible, and a lookup issued in the very cycle of the enable write must still see the old mapping. The stimulus programs a window completely, probes it before and after the commit, rewrites only the destination's upper half, and then disables a window with a lookup in the same cycle as the write. Overlapping windows are built on purpose so that two numbers claim one address, and each side of the overlap and each edge of the range is probed.

// File: rtl/atu_pkg.sv
package atu_pkg;
  localparam int REG_AW = 12;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 64;
  localparam int HALF_W = 32;
  localparam int IDX_W  = 4;
  localparam int EN_BIT = 31;
  localparam int DIR_BIT = 31;

  localparam logic [REG_AW-1:0] OFS_SELECT   = 12'h900;
  localparam logic [REG_AW-1:0] OFS_TYPE     = 12'h904;
  localparam logic [REG_AW-1:0] OFS_ENABLE   = 12'h908;
  localparam logic [REG_AW-1:0] OFS_LOWER_LO = 12'h90C;
  localparam logic [REG_AW-1:0] OFS_LOWER_HI = 12'h910;
  localparam logic [REG_AW-1:0] OFS_UPPER    = 12'h914;
  localparam logic [REG_AW-1:0] OFS_DEST_LO  = 12'h918;
  localparam logic [REG_AW-1:0] OFS_DEST_HI  = 12'h91C;
  localparam logic [REG_AW-1:0] OFS_LINK_CTL = 12'h710;
  localparam logic [REG_AW-1:0] OFS_PHY_STAT = 12'h72C;
  localparam logic [REG_AW-1:0] OFS_SPEED    = 12'h80C;

  localparam logic [DATA_W-1:0] PHY_STAT_VAL = 32'h0000_0010;
  localparam logic [DATA_W-1:0] SPEED_VAL    = 32'h0002_0000;

  // Strobes from register control to the window datapath
  typedef struct packed {
    logic             wrType;
    logic             wrEnable;
    logic             wrLowerLo;
    logic             wrLowerHi;
    logic             wrUpper;
    logic             wrDestLo;
    logic             wrDestHi;
    logic             selIn;
    logic [IDX_W-1:0] selIdx;
  } atuStrobe_t;

  // Stored register values of the selected window
  typedef struct packed {
    logic [ADDR_W-1:0] lower;
    logic [ADDR_W-1:0] dest;
    logic [DATA_W-1:0] upper;
    logic [DATA_W-1:0] typeWord;
    logic [DATA_W-1:0] enableWord;
  } vpView_t;
endpackage

// File: rtl/atu_ctrl.sv
module atu_ctrl
  import atu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic              selDirIn,
  input  logic [IDX_W-1:0]  selIdxIn,
  input  vpView_t           view,
  output atuStrobe_t        strb,
  output logic [DATA_W-1:0] regRdData
);
  logic             selIn;
  logic [IDX_W-1:0] selIdx;

  // Window selection register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      selIn  <= 1'b0;
      selIdx <= '0;
    end else if (regWrEn && regAddr == OFS_SELECT) begin
      selIn  <= selDirIn;
      selIdx <= selIdxIn;
    end
  end

  always_comb begin
    strb           = '0;
    strb.selIn     = selIn;
    strb.selIdx    = selIdx;
    strb.wrType    = regWrEn && (regAddr == OFS_TYPE);
    strb.wrEnable  = regWrEn && (regAddr == OFS_ENABLE);
    strb.wrLowerLo = regWrEn && (regAddr == OFS_LOWER_LO);
    strb.wrLowerHi = regWrEn && (regAddr == OFS_LOWER_HI);
    strb.wrUpper   = regWrEn && (regAddr == OFS_UPPER);
    strb.wrDestLo  = regWrEn && (regAddr == OFS_DEST_LO);
    strb.wrDestHi  = regWrEn && (regAddr == OFS_DEST_HI);
  end

  always_comb begin
    regRdData = '0;
    unique case (regAddr)
      OFS_SELECT: begin
        regRdData[DIR_BIT]     = selIn;
        regRdData[IDX_W-1:0]   = selIdx;
      end
      OFS_TYPE:     regRdData = view.typeWord;
      OFS_ENABLE:   regRdData = view.enableWord;
      OFS_LOWER_LO: regRdData = view.lower[HALF_W-1:0];
      OFS_LOWER_HI: regRdData = view.lower[ADDR_W-1:HALF_W];
      OFS_UPPER:    regRdData = view.upper;
      OFS_DEST_LO:  regRdData = view.dest[HALF_W-1:0];
      OFS_DEST_HI:  regRdData = view.dest[ADDR_W-1:HALF_W];
      OFS_PHY_STAT: regRdData = PHY_STAT_VAL;
      OFS_SPEED:    regRdData = SPEED_VAL;
      default:      regRdData = '0;
    endcase
  end
endmodule

// File: rtl/atu_datapath.sv
module atu_datapath
  import atu_pkg::*;
#(
  parameter int NUM_VP = 4,
  parameter int OFFS_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  atuStrobe_t        strb,
  input  logic [DATA_W-1:0] wrData,
  output vpView_t           view,
  input  logic              lkValid,
  input  logic              lkInbound,
  input  logic [ADDR_W-1:0] lkAddr,
  output logic              resValid,
  output logic              resMiss,
  output logic              resCfg,
  output logic [IDX_W-1:0]  resIndex,
  output logic [ADDR_W-1:0] resAddr,
  output logic [7:0]        resBus,
  output logic [7:0]        resDevFn,
  output logic [OFFS_W-1:0] resOffset
);
  localparam int NDIR = 2;

  // Stored (shadow) register values
  logic [ADDR_W-1:0] shLower [NDIR][NUM_VP];
  logic [ADDR_W-1:0] shDest  [NDIR][NUM_VP];
  logic [DATA_W-1:0] shUpper [NDIR][NUM_VP];
  logic [DATA_W-1:0] shType  [NDIR][NUM_VP];
  logic [DATA_W-1:0] shEn    [NDIR][NUM_VP];
  // Live mapping, reloaded on an enable write
  logic [ADDR_W-1:0] acLower [NDIR][NUM_VP];
  logic [ADDR_W-1:0] acDest  [NDIR][NUM_VP];
  logic              acCfg   [NDIR][NUM_VP];
  logic [NUM_VP-1:0] match   [NDIR];

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    for (genvar v = 0; v < NUM_VP; v++) begin : g_vp
      localparam logic ON_AT_RESET = (d == 1) && (v == 0);
      logic              picked;
      logic [ADDR_W-1:0] sLower, sDest, aLower, aDest;
      logic [DATA_W-1:0] sUpper, sType, sEn, aUpper;
      logic              aCfg, aEn;

      assign picked = (strb.selIn == 1'(d)) && (strb.selIdx == IDX_W'(v));

      always_ff @(posedge clk) begin
        if (!rstN) begin
          sLower <= '0;
          sDest  <= '0;
          sUpper <= '1;
          sType  <= '0;
          sEn    <= {ON_AT_RESET, {(DATA_W-1){1'b0}}};
          aLower <= '0;
          aDest  <= '0;
          aUpper <= '1;
          aCfg   <= 1'b0;
          aEn    <= ON_AT_RESET;
        end else if (picked) begin
          if (strb.wrType)    sType  <= wrData;
          if (strb.wrLowerLo) sLower[HALF_W-1:0] <= wrData;
          if (strb.wrLowerHi) sLower[ADDR_W-1:HALF_W] <= wrData;
          if (strb.wrUpper)   sUpper <= wrData;
          if (strb.wrDestLo)  sDest[HALF_W-1:0] <= wrData;
          if (strb.wrDestHi)  sDest[ADDR_W-1:HALF_W] <= wrData;
          if (strb.wrEnable) begin
            sEn    <= wrData;
            aLower <= sLower;
            aDest  <= sDest;
            aUpper <= sUpper;
            aCfg   <= (sType != '0);
            aEn    <= wrData[EN_BIT];
          end
        end
      end

      assign shLower[d][v] = sLower;
      assign shDest[d][v]  = sDest;
      assign shUpper[d][v] = sUpper;
      assign shType[d][v]  = sType;
      assign shEn[d][v]    = sEn;
      assign acLower[d][v] = aLower;
      assign acDest[d][v]  = aDest;
      assign acCfg[d][v]   = aCfg;
      assign match[d][v]   = aEn && (lkAddr >= aLower) &&
                             (lkAddr <= {aLower[ADDR_W-1:HALF_W], aUpper});
    end
  end

  // Read view of the selected window
  always_comb begin
    view = '0;
    for (int v = 0; v < NUM_VP; v++) begin
      if (strb.selIdx == IDX_W'(v)) begin
        view.lower      = strb.selIn ? shLower[1][v] : shLower[0][v];
        view.dest       = strb.selIn ? shDest[1][v]  : shDest[0][v];
        view.upper      = strb.selIn ? shUpper[1][v] : shUpper[0][v];
        view.typeWord   = strb.selIn ? shType[1][v]  : shType[0][v];
        view.enableWord = strb.selIn ? shEn[1][v]    : shEn[0][v];
      end
    end
  end

  // Priority pick: scan downward so the lowest number is taken last
  logic              hit, hitCfg;
  logic [IDX_W-1:0]  hitIdx;
  logic [ADDR_W-1:0] hitLower, hitDest, delta, xAddr;
  logic [NUM_VP-1:0] dirMatch;

  assign dirMatch = match[lkInbound];

  always_comb begin
    hit      = 1'b0;
    hitCfg   = 1'b0;
    hitIdx   = '0;
    hitLower = '0;
    hitDest  = '0;
    for (int v = NUM_VP - 1; v >= 0; v--) begin
      if (dirMatch[v]) begin
        hit      = 1'b1;
        hitIdx   = IDX_W'(v);
        hitLower = acLower[lkInbound][v];
        hitDest  = acDest[lkInbound][v];
        hitCfg   = acCfg[lkInbound][v];
      end
    end
  end

  assign delta = lkAddr - hitLower;
  assign xAddr = hit ? (hitDest + delta) : lkAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid  <= 1'b0;
      resMiss   <= 1'b0;
      resCfg    <= 1'b0;
      resIndex  <= '0;
      resAddr   <= '0;
      resBus    <= '0;
      resDevFn  <= '0;
      resOffset <= '0;
    end else begin
      resValid <= lkValid;
      if (lkValid) begin
        resMiss   <= !hit;
        resCfg    <= hitCfg;
        resIndex  <= hitIdx;
        resAddr   <= xAddr;
        resBus    <= hitCfg ? hitDest[31:24] : 8'h00;
        resDevFn  <= hitCfg ? hitDest[23:16] : 8'h00;
        resOffset <= hitCfg ? delta[OFFS_W-1:0] : '0;
      end
    end
  end
endmodule

// File: rtl/atu_xlate.sv
module atu_xlate
  import atu_pkg::*;
#(
  parameter int NUM_VP = 4,
  parameter int OFFS_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [11:0]       regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              lkValid,
  input  logic              lkInbound,
  input  logic [63:0]       lkAddr,
  output logic              resValid,
  output logic              resMiss,
  output logic              resCfg,
  output logic [3:0]        resIndex,
  output logic [63:0]       resAddr,
  output logic [7:0]        resBus,
  output logic [7:0]        resDevFn,
  output logic [OFFS_W-1:0] resOffset
);
  atuStrobe_t strb;
  vpView_t    view;

  atu_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .selDirIn (regWrData[DIR_BIT]),
    .selIdxIn (regWrData[IDX_W-1:0]),
    .view     (view),
    .strb     (strb),
    .regRdData(regRdData)
  );

  atu_datapath #(.NUM_VP(NUM_VP), .OFFS_W(OFFS_W)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wrData   (regWrData),
    .view     (view),
    .lkValid  (lkValid),
    .lkInbound(lkInbound),
    .lkAddr   (lkAddr),
    .resValid (resValid),
    .resMiss  (resMiss),
    .resCfg   (resCfg),
    .resIndex (resIndex),
    .resAddr  (resAddr),
    .resBus   (resBus),
    .resDevFn (resDevFn),
    .resOffset(resOffset)
  );
endmodule

// File: rtl/atu_xlate_chk.sv
module atu_xlate_chk #(
  parameter int OFFS_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic [11:0]       regAddr,
  input logic [31:0]       regRdData,
  input logic              lkValid,
  input logic [63:0]       lkAddr,
  input logic              resValid,
  input logic              resMiss,
  input logic              resCfg,
  input logic [3:0]        resIndex,
  input logic [63:0]       resAddr,
  input logic [7:0]        resBus,
  input logic [7:0]        resDevFn,
  input logic [OFFS_W-1:0] resOffset
);
  // R11
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    lkValid |=> resValid);
  // R11
  idle_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lkValid |=> !resValid);
  // R7
  miss_passthru_chk: assert property (@(posedge clk) disable iff (!rstN)
    lkValid |=> (!resMiss || resAddr == $past(lkAddr)));
  // R7
  miss_fields_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resMiss) |-> (!resCfg && resIndex == 4'd0));
  // R8
  cfg_fields_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !resCfg) |-> (resBus == 8'h00 && resDevFn == 8'h00 && resOffset == '0));
  // R10
  phy_stat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 12'h72C) |-> (regRdData == 32'h0000_0010));
  // R2
  select_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 12'h900) |-> (regRdData[30:4] == 27'd0));
endmodule

bind atu_xlate atu_xlate_chk #(.OFFS_W(OFFS_W)) i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .regAddr  (regAddr),
  .regRdData(regRdData),
  .lkValid  (lkValid),
  .lkAddr   (lkAddr),
  .resValid (resValid),
  .resMiss  (resMiss),
  .resCfg   (resCfg),
  .resIndex (resIndex),
  .resAddr  (resAddr),
  .resBus   (resBus),
  .resDevFn (resDevFn),
  .resOffset(resOffset)
);

// File: tb/test_atu_xlate.sv
`timescale 1ns/1ps
module test_atu_xlate;
  localparam int NV = 4;
  localparam int OW = 12;

  logic        clk = 1'b0;
  logic        rstN;
  logic        regWrEn;
  logic [11:0] regAddr;
  logic [31:0] regWrData;
  logic [31:0] regRdData;
  logic        lkValid;
  logic        lkInbound;
  logic [63:0] lkAddr;
  logic        resValid, resMiss, resCfg;
  logic [3:0]  resIndex;
  logic [63:0] resAddr;
  logic [7:0]  resBus, resDevFn;
  logic [OW-1:0] resOffset;

  always #2.5 clk = ~clk;

  atu_xlate #(.NUM_VP(NV), .OFFS_W(OW)) i_atu_xlate (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .lkValid(lkValid),
    .lkInbound(lkInbound), .lkAddr(lkAddr), .resValid(resValid),
    .resMiss(resMiss), .resCfg(resCfg), .resIndex(resIndex),
    .resAddr(resAddr), .resBus(resBus), .resDevFn(resDevFn),
    .resOffset(resOffset)
  );

  int nChk = 0;
  int nFail = 0;
  bit done = 1'b0;

  typedef struct packed {
    logic        v;
    logic        miss;
    logic        cfg;
    logic [3:0]  idx;
    logic [63:0] addr;
    logic [7:0]  bus;
    logic [7:0]  dfn;
    logic [11:0] off;
  } exp_t;

  exp_t expQ[$];

  // Behavioural reference state
  logic [63:0] mLower [2][16];
  logic [63:0] mDest  [2][16];
  logic [31:0] mUpper [2][16];
  logic [31:0] mType  [2][16];
  logic [63:0] lLower [2][16];
  logic [63:0] lDest  [2][16];
  logic [31:0] lUpper [2][16];
  bit          lCfg   [2][16];
  bit          lEn    [2][16];
  int          mDir, mIdx;

  function automatic void modelReset();
    for (int d = 0; d < 2; d++) begin
      for (int i = 0; i < 16; i++) begin
        mLower[d][i] = 0; mDest[d][i] = 0; mUpper[d][i] = 32'hFFFF_FFFF; mType[d][i] = 0;
        lLower[d][i] = 0; lDest[d][i] = 0; lUpper[d][i] = 32'hFFFF_FFFF;
        lCfg[d][i] = 0; lEn[d][i] = (d == 1 && i == 0);
      end
    end
    mDir = 0; mIdx = 0;
  endfunction

  function automatic void modelWrite(input logic [11:0] a, input logic [31:0] dat);
    if (a == 12'h900) begin
      mDir = int'(dat[31]); mIdx = int'(dat[3:0]);
    end else if (mIdx < NV) begin
      case (a)
        12'h904: mType[mDir][mIdx] = dat;
        12'h90C: mLower[mDir][mIdx][31:0] = dat;
        12'h910: mLower[mDir][mIdx][63:32] = dat;
        12'h914: mUpper[mDir][mIdx] = dat;
        12'h918: mDest[mDir][mIdx][31:0] = dat;
        12'h91C: mDest[mDir][mIdx][63:32] = dat;
        12'h908: begin
          lLower[mDir][mIdx] = mLower[mDir][mIdx];
          lDest[mDir][mIdx]  = mDest[mDir][mIdx];
          lUpper[mDir][mIdx] = mUpper[mDir][mIdx];
          lCfg[mDir][mIdx]   = (mType[mDir][mIdx] != 0);
          lEn[mDir][mIdx]    = dat[31];
        end
        default: ;
      endcase
    end
  endfunction

  function automatic exp_t modelLook(input int dir, input logic [63:0] a);
    exp_t e;
    bit found = 0;
    logic [63:0] dlt;
    e = '0; e.v = 1; e.miss = 1; e.addr = a;
    for (int i = 0; i < NV; i++) begin
      if (!found && lEn[dir][i] && a >= lLower[dir][i] &&
          a <= {lLower[dir][i][63:32], lUpper[dir][i]}) begin
        found = 1;
        dlt = a - lLower[dir][i];
        e.miss = 0;
        e.idx = 4'(i);
        e.addr = lDest[dir][i] + dlt;
        e.cfg = lCfg[dir][i];
        if (lCfg[dir][i]) begin
          e.bus = lDest[dir][i][31:24];
          e.dfn = lDest[dir][i][23:16];
          e.off = dlt[11:0];
        end
      end
    end
    return e;
  endfunction

  task automatic step(input bit wr, input logic [11:0] a, input logic [31:0] dat,
                      input bit lv, input bit lin, input logic [63:0] la, input string tag);
    exp_t e;
    regWrEn = wr; regAddr = a; regWrData = dat;
    lkValid = lv; lkInbound = lin; lkAddr = la;
    e = lv ? modelLook(int'(lin), la) : exp_t'(0);
    expQ.push_back(e);
    @(posedge clk);
    if (wr) modelWrite(a, dat);
    @(negedge clk);
    e = expQ.pop_front();
    nChk++;
    if (resValid !== e.v) begin
      nFail++;
      $display("FAIL %s resValid act=%b exp=%b", tag, resValid, e.v);
    end else if (e.v && ({resMiss, resCfg, resIndex, resAddr, resBus, resDevFn, resOffset} !==
                         {e.miss, e.cfg, e.idx, e.addr, e.bus, e.dfn, e.off})) begin
      nFail++;
      $display("FAIL %s act miss=%b cfg=%b idx=%0d addr=%h bus=%h dfn=%h off=%h exp miss=%b cfg=%b idx=%0d addr=%h bus=%h dfn=%h off=%h",
               tag, resMiss, resCfg, resIndex, resAddr, resBus, resDevFn, resOffset,
               e.miss, e.cfg, e.idx, e.addr, e.bus, e.dfn, e.off);
    end
    regWrEn = 0; lkValid = 0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] dat, input string tag);
    step(1, a, dat, 0, 0, 64'h0, tag);
  endtask

  task automatic look(input bit inb, input logic [63:0] a, input string tag);
    step(0, 12'h0, 32'h0, 1, inb, a, tag);
  endtask

  task automatic rdChk(input logic [11:0] a, input logic [31:0] ex, input string tag);
    regWrEn = 0; regAddr = a;
    #1;
    nChk++;
    if (regRdData !== ex) begin
      nFail++;
      $display("FAIL %s read %h act=%h exp=%h", tag, a, regRdData, ex);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    rstN = 0; regWrEn = 0; regAddr = 0; regWrData = 0;
    lkValid = 0; lkInbound = 0; lkAddr = 0;
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    nChk++;
    if (resValid !== 1'b0) begin nFail++; $display("FAIL R1 resValid act=%b exp=0", resValid); end
    rstN = 1;

    // R1 reset state
    rdChk(12'h900, 32'h0, "R1");
    rdChk(12'h914, 32'hFFFF_FFFF, "R1");
    rdChk(12'h908, 32'h0, "R1");
    wr(12'h900, 32'h8000_0000, "R2");
    rdChk(12'h908, 32'h8000_0000, "R1");
    rdChk(12'h904, 32'h0, "R1");
    rdChk(12'h90C, 32'h0, "R1");
    look(1, 64'h1234, "R1");
    look(0, 64'h1234, "R7");

    // R2 selection bits
    wr(12'h900, 32'h7FFF_FFF3, "R2");
    rdChk(12'h900, 32'h0000_0003, "R2");
    wr(12'h900, 32'hFFFF_FFF1, "R2");
    rdChk(12'h900, 32'h8000_0001, "R2");

    // R3/R4/R5 outbound window 1
    wr(12'h900, 32'h1, "R3");
    wr(12'h90C, 32'h1000, "R3");
    wr(12'h910, 32'h0, "R3");
    wr(12'h914, 32'h1FFF, "R3");
    wr(12'h918, 32'h8000_0000, "R3");
    wr(12'h91C, 32'h2, "R3");
    rdChk(12'h918, 32'h8000_0000, "R3");
    rdChk(12'h91C, 32'h2, "R3");
    rdChk(12'h914, 32'h1FFF, "R3");
    look(0, 64'h1800, "R4");
    wr(12'h908, 32'h8000_0000, "R4");
    rdChk(12'h908, 32'h8000_0000, "R3");
    look(0, 64'h1800, "R5");
    look(0, 64'h1FFF, "R5");
    look(0, 64'h2000, "R5");
    look(0, 64'h0FFF, "R5");
    look(0, 64'h1000, "R11");

    // R9 upper destination half
    wr(12'h91C, 32'h7, "R9");
    rdChk(12'h918, 32'h8000_0000, "R9");
    rdChk(12'h91C, 32'h7, "R9");
    look(0, 64'h1800, "R4");
    wr(12'h908, 32'h8000_0000, "R9");
    look(0, 64'h1800, "R9");

    // R6 overlapping window 0
    wr(12'h900, 32'h0, "R6");
    wr(12'h90C, 32'h1800, "R6");
    wr(12'h914, 32'h1FFF, "R6");
    wr(12'h918, 32'h5000, "R6");
    wr(12'h908, 32'h8000_0000, "R6");
    look(0, 64'h1900, "R6");
    look(0, 64'h1100, "R6");

    // R8 configuration window 2
    wr(12'h900, 32'h2, "R8");
    wr(12'h904, 32'h4, "R8");
    wr(12'h90C, 32'h4000_0000, "R8");
    wr(12'h914, 32'h4FFF_FFFF, "R8");
    wr(12'h918, 32'h0312_0000, "R8");
    wr(12'h908, 32'h8000_0000, "R8");
    look(0, 64'h4000_0ABC, "R8");
    look(0, 64'h4000_1004, "R8");

    // R12 direction separation
    look(1, 64'h1900, "R12");

    // R13 out-of-range window number
    wr(12'h900, 32'h9, "R13");
    wr(12'h90C, 32'h55, "R13");
    wr(12'h908, 32'h8000_0000, "R13");
    rdChk(12'h90C, 32'h0, "R13");
    rdChk(12'h908, 32'h0, "R13");
    rdChk(12'h900, 32'h9, "R2");
    wr(12'h900, 32'h0, "R13");
    rdChk(12'h90C, 32'h1800, "R13");
    look(0, 64'h1100, "R13");

    // R10 fixed registers
    wr(12'h72C, 32'h0, "R10");
    rdChk(12'h72C, 32'h0000_0010, "R10");
    wr(12'h80C, 32'h0, "R10");
    rdChk(12'h80C, 32'h0002_0000, "R10");
    wr(12'h710, 32'hFFFF_FFFF, "R10");
    rdChk(12'h710, 32'h0, "R10");
    rdChk(12'h900, 32'h0, "R10");
    rdChk(12'h90C, 32'h1800, "R10");

    // R4 lookup in the same cycle as a disabling enable write
    wr(12'h900, 32'h1, "R4");
    step(1, 12'h908, 32'h0, 1, 0, 64'h1100, "R4");
    look(0, 64'h1100, "R4");

    // R7 inbound window 0 disabled
    wr(12'h900, 32'h8000_0000, "R7");
    wr(12'h908, 32'h0, "R7");
    look(1, 64'h10, "R7");
    step(0, 12'h0, 32'h0, 0, 0, 64'h0, "R11");

    finishRun();
  end
endmodule